// File: doc/BRIEF.md
# Host Signalling Pin Controller

This block sits between a slave controller's port latch and four of its output pins. By default, each of the four pins simply shows the bit the slave last wrote to it. Two single-cycle commands can each switch on a special mode, and once on, a mode stays on until reset.

Flags mode turns the two low pins into host interrupt lines. One line shows that the output buffer is full. The other line shows that the input buffer has room, which is the inverse of its full bit. In both cases the slave's latch bit acts as an enable: a latch bit of 0 forces the pin low.

DMA mode turns the upper two pins into a DMA handshake:
- The third pin becomes a request. The slave sets it by writing a 1.
- The request drops on its own once the host finishes a read or write strobe while the acknowledge line is low.
- The fourth pin becomes the active-low acknowledge input. It is released high, and while low it also selects the buffer registers, in addition to the ordinary host chip select.

All outputs are registered. Each output reflects the inputs sampled at the same clock edge.

Top module: `hsp_pins`

## Requirements
- R1: A synchronous active-high reset sets every latch bit to 1, turns both modes off, clears the request, drives `pin_out` to 4'b1111 and drives `buf_sel_n` to 1.
- R2: A pin whose mode is off outputs its latch bit. `port_wr` high loads `port_wdata` into the latch. Bit 0 maps to the output-full flag pin, bit 1 to the input-full flag pin, bit 2 to the request pin and bit 3 to the acknowledge pin.
- R3: With flags mode on, `pin_out[0]` equals latch bit 0 AND `obf`.
- R4: With flags mode on, `pin_out[1]` equals latch bit 1 AND NOT `ibf`.
- R5: With DMA mode on, `pin_out[2]` shows the request. A port write with bit 2 = 1 sets the request. A port write with bit 2 = 0 leaves it unchanged.
- R6: The request clears in either of two cases. The first is a trailing edge of `host_rd_n` or `host_wr_n` while DMA mode is on and `ack_n` was low in the cycle before. A trailing edge means low at one sample and high at the next. The second is a `dma_en` pulse.
- R7: A port write with bit 2 = 1 in the same cycle as any clearing event leaves the request set.
- R8: With DMA mode on, `pin_out[3]` drives 1, releasing the acknowledge line.
- R9: `buf_sel_n` is 0 when `host_cs_n` is low, or when DMA mode is on and `ack_n` is low. Otherwise it is 1.
- R10: A `flag_en` or `dma_en` pulse takes effect at the edge that samples it, and the mode then holds until reset.
- R11: All outputs change only at a clock edge. Each output reflects the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_wr | input | 1 | Slave write strobe for the pin latch |
| port_wdata | input | 4 | Latch data for the four pins |
| flag_en | input | 1 | One-cycle pulse that enables flags mode |
| dma_en | input | 1 | One-cycle pulse that enables DMA mode and clears the request |
| obf | input | 1 | Output buffer full status |
| ibf | input | 1 | Input buffer full status |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_cs_n | input | 1 | Host chip select, active low |
| ack_n | input | 1 | DMA acknowledge level from the fourth pin, active low |
| pin_out | output | 4 | Registered levels of the four pins |
| buf_sel_n | output | 1 | Registered buffer register select, active low |

## Verification
Every result is due at the edge that samples its cause, with no exception. This holds for a latch write, a mode pulse, a status change, a chip-select change and a request set. The request clear also lands at the edge that samples the strobe high. It uses the acknowledge level from the edge before, because the design remembers one earlier sample of each strobe and of `ack_n`.

The bench drives inputs on the falling edge and updates its model at the rising edge. It compares both outputs at the next falling edge, so each comparison sees exactly one edge of effect. Directed sequences place a strobe's low and high phases in consecutive cycles. They check the request both before and after the releasing edge, and also the case where a set and a clear collide.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int unsigned PIN_W    = 4;
  localparam int unsigned PIN_OBF  = 0;
  localparam int unsigned PIN_IBF  = 1;
  localparam int unsigned PIN_REQ  = 2;
  localparam int unsigned PIN_ACK  = 3;
  localparam int unsigned MODE_W   = 2;
  localparam int unsigned MODE_FLG = 0;
  localparam int unsigned MODE_DMA = 1;
  localparam int unsigned STRB_W   = 2;
endpackage

// File: rtl/hsp_sticky_mode.sv
module hsp_sticky_mode #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_pulse,
  output logic [N-1:0] on_q,
  output logic [N-1:0] on_nxt
);
  for (genvar i = 0; i < N; i++) begin : g_mode
    assign on_nxt[i] = on_q[i] | set_pulse[i];
    always_ff @(posedge clk) begin
      if (rst) on_q[i] <= 1'b0;
      else     on_q[i] <= on_nxt[i];
    end
  end
endmodule

// File: rtl/hsp_trail_det.sv
module hsp_trail_det #(
  parameter int unsigned NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] strb_n,
  input  logic          qual_n,
  output logic          trail_hit
);
  logic [NS-1:0] strb_q;
  logic [NS-1:0] rise;
  logic          qual_q;

  for (genvar s = 0; s < NS; s++) begin : g_strb
    assign rise[s] = ~strb_q[s] & strb_n[s];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= '1;
      qual_q <= 1'b1;
    end else begin
      strb_q <= strb_n;
      qual_q <= qual_n;
    end
  end

  assign trail_hit = (|rise) & ~qual_q;
endmodule

// File: rtl/hsp_req_ctl.sv
module hsp_req_ctl (
  input  logic clk,
  input  logic rst,
  input  logic dma_on,
  input  logic dma_on_nxt,
  input  logic set_wr,
  input  logic trail_hit,
  input  logic rearm,
  output logic req_q,
  output logic req_nxt
);
  always_comb begin
    req_nxt = req_q;
    if (set_wr && dma_on_nxt)            req_nxt = 1'b1;
    else if (rearm || (trail_hit && dma_on)) req_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= req_nxt;
  end
endmodule

// File: rtl/hsp_pins.sv
module hsp_pins
  import hsp_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             port_wr,
  input  logic [PIN_W-1:0] port_wdata,
  input  logic             flag_en,
  input  logic             dma_en,
  input  logic             obf,
  input  logic             ibf,
  input  logic             host_rd_n,
  input  logic             host_wr_n,
  input  logic             host_cs_n,
  input  logic             ack_n,
  output logic [PIN_W-1:0] pin_out,
  output logic             buf_sel_n
);
  logic [MODE_W-1:0] mode_q, mode_nxt;
  logic [PIN_W-1:0]  latch_q, latch_nxt, pin_nxt;
  logic              trail_hit, req_q, req_nxt, sel_nxt;

  hsp_sticky_mode #(.N(MODE_W)) u_mode (
    .clk(clk), .rst(rst),
    .set_pulse({dma_en, flag_en}),
    .on_q(mode_q), .on_nxt(mode_nxt)
  );

  hsp_trail_det #(.NS(STRB_W)) u_trail (
    .clk(clk), .rst(rst),
    .strb_n({host_wr_n, host_rd_n}),
    .qual_n(ack_n),
    .trail_hit(trail_hit)
  );

  hsp_req_ctl u_req (
    .clk(clk), .rst(rst),
    .dma_on(mode_q[MODE_DMA]), .dma_on_nxt(mode_nxt[MODE_DMA]),
    .set_wr(port_wr & port_wdata[PIN_REQ]),
    .trail_hit(trail_hit), .rearm(dma_en),
    .req_q(req_q), .req_nxt(req_nxt)
  );

  assign latch_nxt = port_wr ? port_wdata : latch_q;

  always_comb begin
    pin_nxt = latch_nxt;
    if (mode_nxt[MODE_FLG]) begin
      pin_nxt[PIN_OBF] = latch_nxt[PIN_OBF] & obf;
      pin_nxt[PIN_IBF] = latch_nxt[PIN_IBF] & ~ibf;
    end
    if (mode_nxt[MODE_DMA]) begin
      pin_nxt[PIN_REQ] = req_nxt;
      pin_nxt[PIN_ACK] = 1'b1;
    end
    sel_nxt = ~(~host_cs_n | (mode_nxt[MODE_DMA] & ~ack_n));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q   <= '1;
      pin_out   <= '1;
      buf_sel_n <= 1'b1;
    end else begin
      latch_q   <= latch_nxt;
      pin_out   <= pin_nxt;
      buf_sel_n <= sel_nxt;
    end
  end
endmodule

// File: rtl/hsp_pins_chk.sv
module hsp_pins_chk
  import hsp_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             port_wr,
  input logic [PIN_W-1:0] port_wdata,
  input logic             obf,
  input logic             ibf,
  input logic             host_cs_n,
  input logic [PIN_W-1:0] pin_out,
  input logic             buf_sel_n,
  input logic [MODE_W-1:0] mode_q,
  input logic             req_q
);
  logic armed;
  always_ff @(posedge clk) armed <= ~rst;

  p_reset_pins_r1: assert property (@(posedge clk)
    armed == 1'b0 && $past(rst) |-> pin_out == '1 && buf_sel_n);

  p_obf_gate_r3: assert property (@(posedge clk) disable iff (rst)
    armed && mode_q[MODE_FLG] && !$past(obf) |-> !pin_out[PIN_OBF]);

  p_ibf_gate_r4: assert property (@(posedge clk) disable iff (rst)
    armed && mode_q[MODE_FLG] && $past(ibf) |-> !pin_out[PIN_IBF]);

  p_req_pin_r5: assert property (@(posedge clk) disable iff (rst)
    armed && mode_q[MODE_DMA] |-> pin_out[PIN_REQ] == req_q);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    armed && mode_q[MODE_DMA] && $past(port_wr && port_wdata[PIN_REQ]) |-> req_q);

  p_ack_release_r8: assert property (@(posedge clk) disable iff (rst)
    armed && mode_q[MODE_DMA] |-> pin_out[PIN_ACK]);

  p_host_sel_r9: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(host_cs_n) |-> !buf_sel_n);

  p_mode_hold_r10: assert property (@(posedge clk) disable iff (rst)
    armed && $past(mode_q[MODE_FLG]) |-> mode_q[MODE_FLG]);
endmodule

bind hsp_pins hsp_pins_chk u_hsp_pins_chk (
  .clk(clk), .rst(rst), .port_wr(port_wr), .port_wdata(port_wdata),
  .obf(obf), .ibf(ibf), .host_cs_n(host_cs_n),
  .pin_out(pin_out), .buf_sel_n(buf_sel_n),
  .mode_q(mode_q), .req_q(req_q)
);

// File: tb/hsp_pins_bench.sv
module hsp_pins_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       port_wr = 1'b0;
  logic [3:0] port_wdata = '0;
  logic       flag_en = 1'b0, dma_en = 1'b0, obf = 1'b0, ibf = 1'b0;
  logic       host_rd_n = 1'b1, host_wr_n = 1'b1, host_cs_n = 1'b1, ack_n = 1'b1;
  logic [3:0] pin_out;
  logic       buf_sel_n;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model state
  bit       m_fm, m_dm, m_req, m_rdq, m_wrq, m_ackq;
  bit [3:0] m_lat, m_pin;
  bit       m_sel;

  always #2.5 clk = ~clk;

  hsp_pins u_hsp_pins (
    .clk(clk), .rst(rst), .port_wr(port_wr), .port_wdata(port_wdata),
    .flag_en(flag_en), .dma_en(dma_en), .obf(obf), .ibf(ibf),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_cs_n(host_cs_n),
    .ack_n(ack_n), .pin_out(pin_out), .buf_sel_n(buf_sel_n)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_edge();
    bit fm_n, dm_n, trail, req_n;
    bit [3:0] lat_n;
    if (rst) begin
      m_fm = 0; m_dm = 0; m_req = 0; m_rdq = 1; m_wrq = 1; m_ackq = 1;
      m_lat = 4'hF; m_pin = 4'hF; m_sel = 1;
      return;
    end
    fm_n  = m_fm | flag_en;
    dm_n  = m_dm | dma_en;
    lat_n = port_wr ? port_wdata : m_lat;
    trail = m_dm && !m_ackq && ((!m_rdq && host_rd_n) || (!m_wrq && host_wr_n));
    req_n = m_req;
    if (port_wr && port_wdata[2] && dm_n) req_n = 1;
    else if (dma_en || trail)             req_n = 0;
    m_pin[0] = fm_n ? (lat_n[0] & obf)  : lat_n[0];
    m_pin[1] = fm_n ? (lat_n[1] & !ibf) : lat_n[1];
    m_pin[2] = dm_n ? req_n : lat_n[2];
    m_pin[3] = dm_n ? 1'b1  : lat_n[3];
    m_sel = !(!host_cs_n || (dm_n && !ack_n));
    m_fm = fm_n; m_dm = dm_n; m_lat = lat_n; m_req = req_n;
    m_rdq = host_rd_n; m_wrq = host_wr_n; m_ackq = ack_n;
  endfunction

  // one edge: update model at posedge, compare all outputs at the falling edge
  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(m_fm ? "R3" : "R2", {3'b0, pin_out[0]}, {3'b0, m_pin[0]});
    chk(m_fm ? "R4" : "R2", {3'b0, pin_out[1]}, {3'b0, m_pin[1]});
    chk(m_dm ? "R5" : "R2", {3'b0, pin_out[2]}, {3'b0, m_pin[2]});
    chk(m_dm ? "R8" : "R2", {3'b0, pin_out[3]}, {3'b0, m_pin[3]});
    chk("R9", {3'b0, buf_sel_n}, {3'b0, m_sel});
    port_wr = 0; flag_en = 0; dma_en = 0;
  endtask

  task automatic rand_cycle(input int cmd_odds);
    port_wr    = ($urandom % 4) == 0;
    port_wdata = 4'($urandom);
    flag_en    = ($urandom % cmd_odds) == 0;
    dma_en     = ($urandom % cmd_odds) == 0;
    obf        = 1'($urandom);
    ibf        = 1'($urandom);
    host_rd_n  = ($urandom % 3) != 0;
    host_wr_n  = ($urandom % 3) != 0;
    host_cs_n  = 1'($urandom);
    ack_n      = 1'($urandom);
    tick();
  endtask

  task automatic do_reset();
    rst = 1;
    tick();
    tick();
    rst = 0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    do_reset();
    // R1: reset state, seen before any further stimulus
    chk("R1 pins", pin_out, 4'hF);
    chk("R1 sel", {3'b0, buf_sel_n}, 4'h1);
    // R2: port mode with plain writes
    port_wr = 1; port_wdata = 4'b0101; tick();
    chk("R2 latch", pin_out, 4'b0101);
    for (int i = 0; i < 300; i++) rand_cycle(1000);
    for (int i = 0; i < 1500; i++) rand_cycle(40);

    // directed DMA corner cases
    do_reset();
    port_wr = 1; port_wdata = 4'b0000; tick();
    chk("R2 ack pin low", {3'b0, pin_out[3]}, 4'h0);
    dma_en = 1; port_wr = 1; port_wdata = 4'b0100; tick();
    chk("R10 dma same edge pin3", {3'b0, pin_out[3]}, 4'h1);
    chk("R7 set with enable", {3'b0, pin_out[2]}, 4'h1);
    host_rd_n = 0; ack_n = 0; tick();
    chk("R6 held during strobe", {3'b0, pin_out[2]}, 4'h1);
    chk("R9 ack selects", {3'b0, buf_sel_n}, 4'h0);
    host_rd_n = 1; ack_n = 1; tick();
    chk("R6 rd trailing clears", {3'b0, pin_out[2]}, 4'h0);
    port_wr = 1; port_wdata = 4'b0100; tick();
    chk("R5 write one sets", {3'b0, pin_out[2]}, 4'h1);
    port_wr = 1; port_wdata = 4'b0000; tick();
    chk("R5 write zero keeps", {3'b0, pin_out[2]}, 4'h1);
    host_wr_n = 0; ack_n = 1; tick();
    host_wr_n = 1; tick();
    chk("R6 no ack no clear", {3'b0, pin_out[2]}, 4'h1);
    host_wr_n = 0; ack_n = 0; tick();
    host_wr_n = 1; ack_n = 1; port_wr = 1; port_wdata = 4'b0100; tick();
    chk("R7 write beats trailing clear", {3'b0, pin_out[2]}, 4'h1);
    dma_en = 1; tick();
    chk("R6 enable again clears", {3'b0, pin_out[2]}, 4'h0);
    flag_en = 1; obf = 1; ibf = 0; port_wr = 1; port_wdata = 4'b0011; tick();
    chk("R10 flags same edge", pin_out[1:0], 4'($unsigned(2'b11)));
    obf = 0; ibf = 1; tick();
    chk("R11 status follows next edge", pin_out[1:0], 4'h0);
    for (int i = 0; i < 600; i++) rand_cycle(60);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule